// File: doc/BRIEF.md
# Activity-Count Power Estimator

This block turns access activity from a group of microarchitectural units into an estimate of dynamic energy and average power. Every storage unit drives two strobes, one for a read and one for a write, and every logic unit (a decoder or an ALU, for example) drives one strobe for a logic access. Over an observation window of a programmable number of cycles, the block counts each strobe on its own. It weighs each count by a per-access energy and adds the weighted counts to a programmable constant that stands for static energy.

When a window closes, the counts are frozen and the next window starts at once from zero. Two cycles after the window's last cycle the block presents the total energy and the average power together with a one-cycle valid pulse. Energy is in units of 0.1 nJ and frequency is in MHz, so the power in mW is the energy times the frequency, divided by ten times the window length, with truncation.

Per-access energy is taken as a constant. It does not depend on data values or on how many bits toggle. Counters and accumulators clamp at their largest value and never wrap. All settings are written through a simple write-only register port.

Top module: `act_power_est`

## Requirements
- R1: While reset is held, and after its release until the first result, `res_valid`, `res_energy` and `res_power` are 0. Reset loads all weights and the static term with 0, the window length with `DEF_WIN` and the frequency with `DEF_FREQ`.
- R2: A window lasts exactly L rising edges, where L is the programmed window length and a programmed 0 counts as 1. The length value held in the register at a window's final edge sets the length of the window that follows.
- R3: Each strobe adds one to its own counter for every rising edge of a window at which it is high. All counters start every window from zero, and no event is lost or counted twice across the boundary.
- R4: Read and write strobes of every storage unit carry separate weights. The reported energy is the sum over all strobes of count × weight, plus the static term, in 0.1 nJ units.
- R5: Each logic-access strobe is a separate event class with its own weight, independent of the storage reads and writes.
- R6: A window with no strobes active reports an energy equal to the static term. A strobe that stays low contributes nothing, whatever its weight.
- R7: `res_power` equals floor(E × F / (10 × L)), with E the reported energy, F the frequency register in MHz and L the effective window length.
- R8: An event counter that reaches 2^CNT_W−1 holds that value for the rest of the window.
- R9: Energy above 2^ACC_W−1 is reported as 2^ACC_W−1, and power above 2^PWR_W−1 is reported as 2^PWR_W−1.
- R10: `res_valid` is high for one cycle, at the second rising edge after the window's final edge. The results stay unchanged until the next pulse. The weights, frequency and static term used are those held at the first edge after the window ends.
- R11: Register addresses are: read weights at 0..N_STORE−1, write weights at N_STORE..2·N_STORE−1, logic weights at 2·N_STORE..2·N_STORE+N_LOGIC−1, then window length, frequency and static term at the next three addresses. A write to any other address changes nothing.
- R12: With 20 reads weighted 5 (0.5 nJ) and 12 writes weighted 6 (0.6 nJ) in a window of 50 cycles at 2000 MHz, the block reports energy 172 (17.2 nJ) and power 688 mW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_stb | input | N_STORE | Read strobe per storage unit |
| wr_stb | input | N_STORE | Write strobe per storage unit |
| lg_stb | input | N_LOGIC | Logic-access strobe per logic unit |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | ADDR_W | Register address |
| cfg_wdata | input | REG_W | Register write data (low bits used) |
| res_valid | output | 1 | One-cycle pulse marking new results |
| res_energy | output | ACC_W | Window energy in 0.1 nJ units |
| res_power | output | PWR_W | Average window power in mW |

## Verification
The worked example is run as given, and the other weights are left non-zero while their strobes stay low. This separates true weighting from leakage of idle classes. Staggered strobe patterns, with a different period on each strobe, make each count distinct, so a swapped weight or address shows up in the sum. A test with only the logic weight set isolates the logic class, and a test with no activity isolates the static term. Long windows with every strobe high drive the counters and the energy sum into clamping. Windows of length one and length zero, with a large static term, test the window boundary, the zero-length rule and clamping of the power output.

// File: rtl/apw_pkg.sv
package apw_pkg;
    // energy unit 0.1 nJ times MHz gives 0.1 mW per cycle of window
    localparam int unsigned MW_SCALE = 10;
endpackage

// File: rtl/apw_cfg_regs.sv
module apw_cfg_regs #(
    parameter int N_STORE  = 4,
    parameter int N_LOGIC  = 4,
    parameter int ADDR_W   = 4,
    parameter int REG_W    = 32,
    parameter int E_W      = 8,
    parameter int WIN_W    = 16,
    parameter int FREQ_W   = 16,
    parameter int ACC_W    = 32,
    parameter int DEF_WIN  = 1000,
    parameter int DEF_FREQ = 1000
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_we,
    input  logic [ADDR_W-1:0]               cfg_addr,
    input  logic [REG_W-1:0]                cfg_wdata,
    output logic [N_STORE-1:0][E_W-1:0]     w_rd,
    output logic [N_STORE-1:0][E_W-1:0]     w_wr,
    output logic [N_LOGIC-1:0][E_W-1:0]     w_lg,
    output logic [WIN_W-1:0]                win_len,
    output logic [FREQ_W-1:0]               freq,
    output logic [ACC_W-1:0]                stat_e
);
    localparam logic [ADDR_W-1:0] A_WIN  = ADDR_W'(2 * N_STORE + N_LOGIC);
    localparam logic [ADDR_W-1:0] A_FREQ = ADDR_W'(2 * N_STORE + N_LOGIC + 1);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2 * N_STORE + N_LOGIC + 2);

    typedef struct packed {
        logic [N_STORE-1:0][E_W-1:0] rd;
        logic [N_STORE-1:0][E_W-1:0] wr;
        logic [N_LOGIC-1:0][E_W-1:0] lg;
        logic [WIN_W-1:0]            win;
        logic [FREQ_W-1:0]           fr;
        logic [ACC_W-1:0]            st;
    } regs_t;

    regs_t r_d, r_q;

    // R11 address decode
    always_comb begin
        r_d = r_q;
        if (cfg_we) begin
            for (int i = 0; i < N_STORE; i++) begin
                if (cfg_addr == ADDR_W'(i))
                    r_d.rd[i] = cfg_wdata[E_W-1:0];
                if (cfg_addr == ADDR_W'(N_STORE + i))
                    r_d.wr[i] = cfg_wdata[E_W-1:0];
            end
            for (int j = 0; j < N_LOGIC; j++) begin
                if (cfg_addr == ADDR_W'(2 * N_STORE + j))
                    r_d.lg[j] = cfg_wdata[E_W-1:0];
            end
            if (cfg_addr == A_WIN)  r_d.win = cfg_wdata[WIN_W-1:0];
            if (cfg_addr == A_FREQ) r_d.fr  = cfg_wdata[FREQ_W-1:0];
            if (cfg_addr == A_STAT) r_d.st  = cfg_wdata[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.rd  <= '0;
            r_q.wr  <= '0;
            r_q.lg  <= '0;
            r_q.win <= WIN_W'(DEF_WIN);
            r_q.fr  <= FREQ_W'(DEF_FREQ);
            r_q.st  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign w_rd    = r_q.rd;
    assign w_wr    = r_q.wr;
    assign w_lg    = r_q.lg;
    assign win_len = r_q.win;
    assign freq    = r_q.fr;
    assign stat_e  = r_q.st;

    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(r_q));
endmodule

// File: rtl/apw_evt_ctr.sv
module apw_evt_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic             win_end,
    output logic [CNT_W-1:0] snap
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] snap;
    } ctr_t;

    ctr_t c_d, c_q;
    logic [CNT_W-1:0] incl;

    always_comb begin
        c_d  = c_q;
        incl = (stb && (c_q.cnt != CMAX)) ? c_q.cnt + CNT_W'(1) : c_q.cnt;
        if (win_end) begin
            c_d.cnt  = '0;
            c_d.snap = incl;
        end else begin
            c_d.cnt  = incl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign snap = c_q.snap;

    // R8
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.cnt == CMAX && stb && !win_end) |=> (c_q.cnt == CMAX));
    // R3
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (c_q.cnt == '0));
endmodule

// File: rtl/apw_calc.sv
module apw_calc import apw_pkg::*; #(
    parameter int N_EVT  = 12,
    parameter int CNT_W  = 16,
    parameter int E_W    = 8,
    parameter int ACC_W  = 32,
    parameter int WIN_W  = 16,
    parameter int FREQ_W = 16,
    parameter int PWR_W  = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          snap_vld,
    input  logic [N_EVT-1:0][CNT_W-1:0]   snaps,
    input  logic [N_EVT-1:0][E_W-1:0]     weights,
    input  logic [ACC_W-1:0]              stat_e,
    input  logic [FREQ_W-1:0]             freq,
    input  logic [WIN_W-1:0]              win_len,
    output logic                          res_valid,
    output logic [ACC_W-1:0]              res_energy,
    output logic [PWR_W-1:0]              res_power
);
    localparam int PROD_W = CNT_W + E_W;
    localparam int BASE_W = (PROD_W > ACC_W) ? PROD_W : ACC_W;
    localparam int SUM_W  = BASE_W + $clog2(N_EVT + 1) + 1;
    localparam int NUM_W  = ACC_W + FREQ_W;
    localparam int DEN_W  = WIN_W + 4;
    localparam logic [ACC_W-1:0] EMAX = '1;
    localparam logic [PWR_W-1:0] PMAX = '1;

    typedef struct packed {
        logic              v1;
        logic [ACC_W-1:0]  e1;
        logic [FREQ_W-1:0] f1;
        logic [WIN_W-1:0]  w1;
        logic              vo;
        logic [ACC_W-1:0]  eo;
        logic [PWR_W-1:0]  po;
    } calc_t;

    calc_t s_d, s_q;
    logic [SUM_W-1:0] acc;
    logic [ACC_W-1:0] e_sat;
    logic [NUM_W-1:0] num, quot;
    logic [DEN_W-1:0] den;
    logic [PWR_W-1:0] p_sat;

    // weighted sum of frozen counts plus static term
    always_comb begin
        acc = {{(SUM_W-ACC_W){1'b0}}, stat_e};
        for (int i = 0; i < N_EVT; i++) begin
            acc = acc + ({{(SUM_W-CNT_W){1'b0}}, snaps[i]} *
                         {{(SUM_W-E_W){1'b0}}, weights[i]});
        end
        e_sat = (acc > {{(SUM_W-ACC_W){1'b0}}, EMAX}) ? EMAX : acc[ACC_W-1:0];
    end

    // power divide on the registered energy
    always_comb begin
        num   = {{FREQ_W{1'b0}}, s_q.e1} * {{ACC_W{1'b0}}, s_q.f1};
        den   = {4'b0, s_q.w1} * DEN_W'(MW_SCALE);
        quot  = num / {{(NUM_W-DEN_W){1'b0}}, den};
        p_sat = (quot > {{(NUM_W-PWR_W){1'b0}}, PMAX}) ? PMAX : quot[PWR_W-1:0];
    end

    always_comb begin
        s_d    = s_q;
        s_d.v1 = snap_vld;
        if (snap_vld) begin
            s_d.e1 = e_sat;
            s_d.f1 = freq;
            s_d.w1 = win_len;
        end
        s_d.vo = s_q.v1;
        if (s_q.v1) begin
            s_d.eo = s_q.e1;
            s_d.po = p_sat;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.w1 <= WIN_W'(1);
        end else begin
            s_q <= s_d;
        end
    end

    assign res_valid  = s_q.vo;
    assign res_energy = s_q.eo;
    assign res_power  = s_q.po;

    // R10
    res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap_vld |-> ##2 res_valid);
    // R6
    static_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap_vld |=> (s_q.e1 >= $past(stat_e)));
    // R10
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.v1 |=> ($stable(res_energy) && $stable(res_power)));
endmodule

// File: rtl/act_power_est.sv
module act_power_est #(
    parameter int N_STORE  = 4,
    parameter int N_LOGIC  = 4,
    parameter int CNT_W    = 16,
    parameter int E_W      = 8,
    parameter int ACC_W    = 32,
    parameter int WIN_W    = 16,
    parameter int FREQ_W   = 16,
    parameter int PWR_W    = 32,
    parameter int ADDR_W   = 4,
    parameter int REG_W    = 32,
    parameter int DEF_WIN  = 1000,
    parameter int DEF_FREQ = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_STORE-1:0] rd_stb,
    input  logic [N_STORE-1:0] wr_stb,
    input  logic [N_LOGIC-1:0] lg_stb,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [REG_W-1:0]   cfg_wdata,
    output logic               res_valid,
    output logic [ACC_W-1:0]   res_energy,
    output logic [PWR_W-1:0]   res_power
);
    localparam int N_EVT = 2 * N_STORE + N_LOGIC;

    logic [N_STORE-1:0][E_W-1:0] w_rd, w_wr;
    logic [N_LOGIC-1:0][E_W-1:0] w_lg;
    logic [WIN_W-1:0]            cfg_win;
    logic [FREQ_W-1:0]           cfg_freq;
    logic [ACC_W-1:0]            cfg_stat;

    logic [N_EVT-1:0]            evt;
    logic [N_EVT-1:0][E_W-1:0]   weights;
    logic [N_EVT-1:0][CNT_W-1:0] snaps;

    apw_cfg_regs #(
        .N_STORE(N_STORE), .N_LOGIC(N_LOGIC), .ADDR_W(ADDR_W), .REG_W(REG_W),
        .E_W(E_W), .WIN_W(WIN_W), .FREQ_W(FREQ_W), .ACC_W(ACC_W),
        .DEF_WIN(DEF_WIN), .DEF_FREQ(DEF_FREQ)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .w_rd(w_rd), .w_wr(w_wr), .w_lg(w_lg),
        .win_len(cfg_win), .freq(cfg_freq), .stat_e(cfg_stat)
    );

    // event order: reads, then writes, then logic accesses
    assign evt     = {lg_stb, wr_stb, rd_stb};
    assign weights = {w_lg, w_wr, w_rd};

    // window timer
    typedef struct packed {
        logic [WIN_W-1:0] wcnt;
        logic [WIN_W-1:0] wact;
        logic             sv;
        logic [WIN_W-1:0] swin;
    } tmr_t;

    tmr_t t_d, t_q;
    logic win_end;
    logic [WIN_W-1:0] win_next;

    always_comb begin
        t_d      = t_q;
        win_end  = (t_q.wcnt == t_q.wact - WIN_W'(1));
        win_next = (cfg_win == '0) ? WIN_W'(1) : cfg_win;
        t_d.sv   = win_end;
        if (win_end) begin
            t_d.wcnt = '0;
            t_d.wact = win_next;
            t_d.swin = t_q.wact;
        end else begin
            t_d.wcnt = t_q.wcnt + WIN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q.wcnt <= '0;
            t_q.wact <= (DEF_WIN == 0) ? WIN_W'(1) : WIN_W'(DEF_WIN);
            t_q.sv   <= 1'b0;
            t_q.swin <= WIN_W'(1);
        end else begin
            t_q <= t_d;
        end
    end

    for (genvar g = 0; g < N_EVT; g++) begin : g_ctr
        apw_evt_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk(clk), .rst_n(rst_n), .stb(evt[g]),
            .win_end(win_end), .snap(snaps[g])
        );
    end

    apw_calc #(
        .N_EVT(N_EVT), .CNT_W(CNT_W), .E_W(E_W), .ACC_W(ACC_W),
        .WIN_W(WIN_W), .FREQ_W(FREQ_W), .PWR_W(PWR_W)
    ) u_calc (
        .clk(clk), .rst_n(rst_n), .snap_vld(t_q.sv), .snaps(snaps),
        .weights(weights), .stat_e(cfg_stat), .freq(cfg_freq),
        .win_len(t_q.swin), .res_valid(res_valid),
        .res_energy(res_energy), .res_power(res_power)
    );

    // R2
    win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.wact != '0) && (t_q.wcnt < t_q.wact));
    // R2
    win_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (t_q.wcnt == '0) && t_q.sv);
endmodule

// File: tb/act_power_est_bench.sv
module act_power_est_bench;
    localparam int SETUP_LEN = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  rd_stb = '0;
    logic [1:0]  wr_stb = '0;
    logic [0:0]  lg_stb = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        res_valid;
    logic [15:0] res_energy;
    logic [15:0] res_power;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    bit      pend = 1'b0;
    longint  pend_e, pend_p;
    string   pend_te, pend_tp;

    always #5 clk = ~clk;

    act_power_est #(
        .N_STORE(2), .N_LOGIC(1), .CNT_W(8), .E_W(8), .ACC_W(16),
        .WIN_W(10), .FREQ_W(12), .PWR_W(16), .ADDR_W(4), .REG_W(16),
        .DEF_WIN(SETUP_LEN), .DEF_FREQ(100)
    ) u_act_power_est (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .lg_stb(lg_stb), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .res_valid(res_valid),
        .res_energy(res_energy), .res_power(res_power)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // strobe pattern: bit0 rd0, bit1 rd1, bit2 wr0, bit3 wr1, bit4 lg0
    function automatic logic [4:0] pat(input int mode, input int c);
        logic [4:0] p;
        p = '0;
        case (mode)
            0: begin p[0] = (c < 20); p[2] = (c < 12); end
            1: p = '1;
            2: begin
                p[0] = (c % 2 == 0);
                p[1] = (c % 3 == 0);
                p[2] = (c % 5 == 1);
                p[3] = (c % 7 == 3);
                p[4] = (c % 4 != 0);
            end
            default: p = '0;
        endcase
        return p;
    endfunction

    task automatic wr_reg(input int a, input int d);
        cfg_we    = 1'b1;
        cfg_addr  = 4'(a);
        cfg_wdata = 16'(d);
    endtask

    // setup window: checks the previous test and loads the next one
    task automatic setup_win(input int nwr, input int w0, input int w1,
                             input int w2, input int w3, input int w4,
                             input int fr, input int st);
        for (int c = 0; c < SETUP_LEN; c++) begin
            if (c == 2 && pend) begin
                chk("R10 valid pulse", res_valid, 1);
                chk(pend_te, res_energy, pend_e);
                chk(pend_tp, res_power, pend_p);
            end
            if (c == 3 && pend) begin
                chk("R10 pulse width", res_valid, 0);
                chk("R10 results held", res_energy, pend_e);
                pend = 1'b0;
            end
            cfg_we = 1'b0;
            rd_stb = '0; wr_stb = '0; lg_stb = '0;
            // R11 register map
            case (c)
                2:  wr_reg(0, w0);
                3:  wr_reg(1, w1);
                4:  wr_reg(2, w2);
                5:  wr_reg(3, w3);
                6:  wr_reg(4, w4);
                7:  wr_reg(6, fr);
                8:  wr_reg(7, st);
                9:  wr_reg(5, nwr);
                10: wr_reg(9, 16'hffff);
                11: wr_reg(5, SETUP_LEN);
                default: ;
            endcase
            @(negedge clk);
        end
        cfg_we = 1'b0;
    endtask

    task automatic run_test(input string te, input string tp, input int mode,
                            input int nwr, input int w0, input int w1,
                            input int w2, input int w3, input int w4,
                            input int fr, input int st);
        int     n;
        longint cnt [5];
        longint w [5];
        longint e, p;
        logic [4:0] s;
        setup_win(nwr, w0, w1, w2, w3, w4, fr, st);
        n = (nwr == 0) ? 1 : nwr;
        w[0] = w0; w[1] = w1; w[2] = w2; w[3] = w3; w[4] = w4;
        for (int k = 0; k < 5; k++) cnt[k] = 0;
        for (int c = 0; c < n; c++) begin
            s = pat(mode, c);
            rd_stb = s[1:0];
            wr_stb = s[3:2];
            lg_stb = s[4:4];
            for (int k = 0; k < 5; k++)
                if (s[k] && cnt[k] < 255) cnt[k]++;
            @(negedge clk);
        end
        e = st;
        for (int k = 0; k < 5; k++) e += cnt[k] * w[k];
        if (e > 65535) e = 65535;
        p = (e * fr) / (10 * n);
        if (p > 65535) p = 65535;
        pend_e = e; pend_p = p; pend_te = te; pend_tp = tp;
        pend = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", res_valid, 0);
        chk("R1 energy in reset", res_energy, 0);
        chk("R1 power in reset", res_power, 0);
        rst_n = 1'b1;
        chk("R1 valid after reset", res_valid, 0);
        // R12 worked example, idle classes weighted but silent (R6)
        run_test("R12 energy", "R12 power", 0, 50, 5, 7, 6, 9, 3, 2000, 0);
        // R4 staggered patterns with static term
        run_test("R4 energy mixed", "R7 power mixed", 2, 40, 3, 4, 5, 6, 7, 1000, 10);
        // R5 logic class alone
        run_test("R5 logic energy", "R7 power logic", 1, 30, 0, 0, 0, 0, 9, 500, 0);
        // R6 no activity, static only; R7 truncation
        run_test("R6 static only", "R7 truncating power", 3, 20, 9, 9, 9, 9, 9, 100, 55);
        // R8 counter clamp at 255
        run_test("R8 counter clamp", "R7 power clamp test", 1, 300, 1, 0, 0, 0, 0, 10, 0);
        // R9 energy clamp
        run_test("R9 energy clamp", "R7 power of clamped", 1, 300, 255, 255, 255, 255, 255, 1, 0);
        // R2 zero length treated as one
        run_test("R2 zero length energy", "R2 zero length power", 1, 0, 1, 2, 3, 4, 5, 4000, 0);
        // R9 power clamp with one-cycle window
        run_test("R9 energy static max", "R9 power clamp", 3, 1, 0, 0, 0, 0, 0, 4095, 65535);
        // R3 odd window with staggered strobes
        run_test("R3 odd window energy", "R7 odd window power", 2, 97, 11, 13, 17, 19, 23, 3333, 2);
        setup_win(SETUP_LEN, 0, 0, 0, 0, 0, 100, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule